// File: doc/BRIEF.md
# Interlocked Strobe-Handshake Write Master

This block runs single write transfers on an asynchronous parallel bus. The bus uses active-low strobes and an active-low acknowledge from the slave. A host raises a one-cycle request together with an address and a data word. The master then drives the bus one step per clock:

- address valid
- address strobe low
- direction line at the write level (low)
- data valid
- data strobes low

It then waits, for as long as the slave needs, until the acknowledge goes low. The release is the mirror image, one step per clock: address strobe high, data strobes high, direction line high. The master waits for the acknowledge to return high before it releases the data bus, and it releases the address bus one clock after that.

The acknowledge input is brought into the clock domain through two flops. A programmable cycle limit bounds both acknowledge waits. When the limit runs out, all strobes are negated, both buses are released and a one-cycle bus-error flag is raised. A successful transfer ends with a one-cycle done pulse on the first idle cycle.

Top module: `hs_wr_master`

## Requirements
- R1: After reset, and whenever idle, the address strobe, all data strobes and the direction line are high. Both bus enables are low, both bus value outputs are zero, and busy, done and bus error are low.
- R2: A start pulse while idle latches the address and data inputs. Busy is high from the next cycle until the master is idle again.
- R3: The drive steps are, one clock each and in this order: address enable high, address strobe low, direction line low, data enable high, data strobes low.
- R4: While the data strobes are low, the address and data outputs carry the values latched at the start.
- R5: After the acknowledge is seen low, the address strobe rises, the data strobes rise one clock later, and the direction line rises one clock after that.
- R6: The data enable falls only after the synchronized acknowledge is high again. The address enable falls one clock after the data enable.
- R7: A successful transfer gives a done pulse of exactly one cycle, on the first idle cycle, with busy low.
- R8: Each wait (strobes low waiting for acknowledge low, and direction line high waiting for acknowledge high) is bounded by a limit L. If the awaited level has not been seen in the first L+1 cycles of the wait, the next cycle raises bus error for one cycle with everything released, and the master then goes idle. If the awaited level arrives in the last allowed cycle, it wins over the timeout.
- R9: A start pulse while busy is ignored. The latched address and data do not change, and no second transfer follows.
- R10: The acknowledge passes two synchronizing flops. A low level driven just after a clock edge makes the address strobe rise three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle write request |
| addr_i | input | AW | Write address |
| data_i | input | DW | Write data |
| tmo_limit_i | input | TW | Wait limit L; a wait may last L+1 cycles |
| ack_n_i | input | 1 | Active-low acknowledge from the slave (asynchronous) |
| addr_o | output | AW | Address bus value (zero while released) |
| addr_oe_o | output | 1 | Address bus output enable |
| as_n_o | output | 1 | Active-low address strobe |
| rw_n_o | output | 1 | Direction line, low for write |
| data_o | output | DW | Data bus value (zero while released) |
| data_oe_o | output | 1 | Data bus output enable |
| ds_n_o | output | NDS | Active-low data strobes |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle success pulse |
| berr_o | output | 1 | One-cycle timeout flag |

## Verification
The bench records every change of the five control outputs and compares the recorded order with the expected ladder. A master that merged two steps, or released the data before the acknowledge went high again, would produce a different list. It places the acknowledge exactly on the last allowed wait cycle, to catch a timeout that wins over a valid response. It also checks that a limit of zero expires after one cycle, and that a slave which never releases the acknowledge causes a bus error in the second wait rather than a hang. A start pulse injected during the strobe phase must leave the bus address unchanged and must not start a second transfer. The bench also measures the acknowledge-to-release latency, which exposes a missing or extra synchronizer stage.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ASTB, ST_WRLV, ST_DATA, ST_DSTB,
    ST_RLAS, ST_RLDS, ST_RLRW, ST_RLDT, ST_BERR
  } hsw_state_e;

  typedef struct packed {
    logic addr_oe;
    logic as_n;
    logic rw_n;
    logic data_oe;
    logic ds_n;
  } hsw_drive_t;

  // Bus levels held in each state of the ladder
  function automatic hsw_drive_t hsw_drive(input hsw_state_e s);
    hsw_drive_t d;
    d = '{addr_oe: 1'b0, as_n: 1'b1, rw_n: 1'b1, data_oe: 1'b0, ds_n: 1'b1};
    case (s)
      ST_ADDR: d.addr_oe = 1'b1;
      ST_ASTB: begin d.addr_oe = 1'b1; d.as_n = 1'b0; end
      ST_WRLV: begin d.addr_oe = 1'b1; d.as_n = 1'b0; d.rw_n = 1'b0; end
      ST_DATA: begin d.addr_oe = 1'b1; d.as_n = 1'b0; d.rw_n = 1'b0; d.data_oe = 1'b1; end
      ST_DSTB: begin d.addr_oe = 1'b1; d.as_n = 1'b0; d.rw_n = 1'b0; d.data_oe = 1'b1; d.ds_n = 1'b0; end
      ST_RLAS: begin d.addr_oe = 1'b1; d.rw_n = 1'b0; d.data_oe = 1'b1; d.ds_n = 1'b0; end
      ST_RLDS: begin d.addr_oe = 1'b1; d.rw_n = 1'b0; d.data_oe = 1'b1; end
      ST_RLRW: begin d.addr_oe = 1'b1; d.data_oe = 1'b1; end
      ST_RLDT: d.addr_oe = 1'b1;
      default: ;
    endcase
    return d;
  endfunction

  function automatic logic hsw_is_wait(input hsw_state_e s);
    return (s == ST_DSTB) || (s == ST_RLRW);
  endfunction

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hsw_timer.sv
module hsw_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!wait_i)          cnt_q <= '0;
    else if (cnt_q != limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = wait_i && (cnt_q == limit_i);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_i |-> (cnt_q <= limit_i));
endmodule

// File: rtl/hsw_seq.sv
module hsw_seq
  import hsw_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int NDS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  data_i,
  input  logic           ack_s_i,
  input  logic           expired_i,
  output logic [AW-1:0]  addr_o,
  output logic           addr_oe_o,
  output logic           as_n_o,
  output logic           rw_n_o,
  output logic [DW-1:0]  data_o,
  output logic           data_oe_o,
  output logic [NDS-1:0] ds_n_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           berr_o,
  output logic           wait_o,
  output logic           ack_seen_o
);
  hsw_state_e state_q, state_d;
  hsw_drive_t drv;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          done_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_ASTB;
      ST_ASTB: state_d = ST_WRLV;
      ST_WRLV: state_d = ST_DATA;
      ST_DATA: state_d = ST_DSTB;
      ST_DSTB: if (!ack_s_i) state_d = ST_RLAS;
               else if (expired_i) state_d = ST_BERR;
      ST_RLAS: state_d = ST_RLDS;
      ST_RLDS: state_d = ST_RLRW;
      ST_RLRW: if (ack_s_i) state_d = ST_RLDT;
               else if (expired_i) state_d = ST_BERR;
      ST_RLDT: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_RLDT);
      if (state_q == ST_IDLE && start_i) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign drv        = hsw_drive(state_q);
  assign addr_oe_o  = drv.addr_oe;
  assign as_n_o     = drv.as_n;
  assign rw_n_o     = drv.rw_n;
  assign data_oe_o  = drv.data_oe;
  assign addr_o     = drv.addr_oe ? addr_q : '0;
  assign data_o     = drv.data_oe ? data_q : '0;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign berr_o     = (state_q == ST_BERR);
  assign wait_o     = hsw_is_wait(state_q);
  assign ack_seen_o = (state_q == ST_DSTB) && !ack_s_i;

  for (genvar g = 0; g < NDS; g++) begin : g_ds
    assign ds_n_o[g] = drv.ds_n;
  end

  // R3
  as_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_n_o) |-> $past(addr_oe_o));
  // R3
  ds_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ds_n_o[0]) |-> ($past(data_oe_o) && !rw_n_o));
  // R5
  rw_after_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rw_n_o) && !berr_o) |-> ($past(ds_n_o[0]) && $past(as_n_o)));
  // R6
  data_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(data_oe_o) && !berr_o) |-> $past(ack_s_i));
  // R6
  addr_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(addr_oe_o) && !berr_o) |-> $past(!data_oe_o));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && as_n_o && !addr_oe_o && !data_oe_o));
  // R8
  berr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |=> (!berr_o && !busy_o));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/hs_wr_master.sv
module hs_wr_master #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int NDS = 2,
  parameter int TW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  data_i,
  input  logic [TW-1:0]  tmo_limit_i,
  input  logic           ack_n_i,
  output logic [AW-1:0]  addr_o,
  output logic           addr_oe_o,
  output logic           as_n_o,
  output logic           rw_n_o,
  output logic [DW-1:0]  data_o,
  output logic           data_oe_o,
  output logic [NDS-1:0] ds_n_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           berr_o
);
  logic ack_s_w, expired_w, wait_w, ack_seen_w;

  hsw_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ack_n_i), .q_o(ack_s_w)
  );

  hsw_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .wait_i(wait_w),
    .limit_i(tmo_limit_i), .expired_o(expired_w)
  );

  hsw_seq #(.AW(AW), .DW(DW), .NDS(NDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .data_i(data_i), .ack_s_i(ack_s_w), .expired_i(expired_w),
    .addr_o(addr_o), .addr_oe_o(addr_oe_o), .as_n_o(as_n_o),
    .rw_n_o(rw_n_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .ds_n_o(ds_n_o), .busy_o(busy_o), .done_o(done_o),
    .berr_o(berr_o), .wait_o(wait_w), .ack_seen_o(ack_seen_w)
  );

  // R10
  ack_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_seen_w |-> ($past(ack_n_i, 2) == 1'b0));
endmodule

// File: tb/hs_wr_master_tb_top.sv
`timescale 1ns/1ps
module hs_wr_master_tb_top;
  localparam int AW = 16, DW = 16, NDS = 2, TW = 8;
  localparam logic [4:0] IDLE_V = 5'h0D;
  // {addr_oe, as_n, rw_n, data_oe, all ds_n high}
  localparam logic [4:0] EXP_OK [10] = '{5'h1D, 5'h15, 5'h11, 5'h13, 5'h12,
                                         5'h1A, 5'h1B, 5'h1F, 5'h1D, 5'h0D};
  // {addr, data, ack delay, release delay, limit, mode}; mode 0 ok, 1 ack-wait error, 2 release-wait error
  localparam logic [63:0] VEC [6] = '{
    {16'h1234, 16'hABCD, 8'd1,   8'd1,   8'd20, 8'd0},
    {16'hFFFF, 16'h0000, 8'd6,   8'd9,   8'd20, 8'd0},
    {16'h0001, 16'h8001, 8'd0,   8'd0,   8'd2,  8'd0},
    {16'h00F0, 16'h0F0F, 8'd255, 8'd0,   8'd5,  8'd1},
    {16'h7777, 16'h1111, 8'd2,   8'd255, 8'd6,  8'd2},
    {16'hC0DE, 16'h2468, 8'd0,   8'd0,   8'd0,  8'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ack_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [TW-1:0] tmo_lim = '0;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o;
  logic addr_oe, as_n, rw_n, data_oe, busy, done_o, berr_o;
  logic [NDS-1:0] ds_n;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hs_wr_master #(.AW(AW), .DW(DW), .NDS(NDS), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .data_i(data),
    .tmo_limit_i(tmo_lim), .ack_n_i(ack_n), .addr_o(addr_o),
    .addr_oe_o(addr_oe), .as_n_o(as_n), .rw_n_o(rw_n), .data_o(data_o),
    .data_oe_o(data_oe), .ds_n_o(ds_n), .busy_o(busy), .done_o(done_o),
    .berr_o(berr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] bus_vec();
    return {addr_oe, as_n, rw_n, data_oe, &ds_n};
  endfunction

  task automatic run_vec(input logic [15:0] a, input logic [15:0] d, input int dack,
                         input int drel, input int tmo, input int mode, input bit inject);
    logic [4:0] seq [16];
    logic [4:0] v, prev;
    int n = 0, cyc = 0, ca = 0, cr = 0;
    int t_ds = -1, t_ack = -1, t_rel = -1, t_end = -1;
    bit got_done = 0, got_berr = 0, addr_ok = 1, busy_ok = 1, injected = 0;
    logic [4:0] berr_v = '0;
    prev = IDLE_V;
    for (int i = 0; i < 16; i++) seq[i] = '0;
    @(negedge clk); start = 1'b1; addr = a; data = d; tmo_lim = tmo[TW-1:0];
    @(negedge clk); start = 1'b0;
    while (cyc < 300 && !got_done && !got_berr) begin
      start = 1'b0;
      v = bus_vec();
      if (v != prev) begin
        if (n < 16) seq[n] = v;
        n++;
        prev = v;
      end
      if (!done_o && !busy) busy_ok = 0;
      if (done_o) begin got_done = 1; t_end = cyc; end
      if (berr_o) begin got_berr = 1; t_end = cyc; berr_v = v; end
      if (t_ack >= 0 && t_rel < 0 && as_n) t_rel = cyc;
      if (ds_n != '1) begin
        if (t_ds < 0) t_ds = cyc;
        if (addr_o != a || data_o != d) addr_ok = 0;
        if (inject && !injected) begin
          start = 1'b1; addr = ~a; data = ~d; injected = 1;
        end
        if (ack_n && dack < 255) begin
          if (ca >= dack) begin ack_n = 1'b0; t_ack = cyc; end
          ca++;
        end
      end else if (!ack_n) begin
        if (drel < 255 && cr >= drel) ack_n = 1'b1;
        cr++;
      end
      @(negedge clk); cyc++;
    end
    if (mode == 0) begin
      chk(got_done && !got_berr, "R7 done", int'(got_done), 1);
      chk(n == 10, "R3 step count", n, 10);
      for (int i = 0; i < 5; i++)
        chk(seq[i] == EXP_OK[i], "R3 drive order", seq[i], EXP_OK[i]);
      for (int i = 5; i < 8; i++)
        chk(seq[i] == EXP_OK[i], "R5 release order", seq[i], EXP_OK[i]);
      for (int i = 8; i < 10; i++)
        chk(seq[i] == EXP_OK[i], "R6 bus release order", seq[i], EXP_OK[i]);
      chk(addr_ok, "R4 bus values held", int'(addr_ok), 1);
      chk(busy_ok, "R2 busy held", int'(busy_ok), 1);
      chk(t_rel - t_ack == 3, "R10 ack latency", t_rel - t_ack, 3);
      chk(!done_o && !busy, "R7 done single cycle", int'(done_o), 0);
    end else begin
      chk(got_berr && !got_done, "R8 bus error", int'(got_berr), 1);
      chk(berr_v == IDLE_V, "R8 released on error", berr_v, IDLE_V);
      if (mode == 1)
        chk(t_end - t_ds == tmo + 1, "R8 timeout length", t_end - t_ds, tmo + 1);
      else
        chk(n >= 2 && seq[n-2] == 5'h1F, "R8 second wait timeout", (n >= 2) ? int'(seq[n-2]) : 0, 5'h1F);
      chk(!berr_o && !busy, "R8 single cycle then idle", int'(berr_o), 0);
    end
    ack_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_vec() == IDLE_V && ds_n == '1, "R1 reset levels", bus_vec(), IDLE_V);
    chk(addr_o == '0 && data_o == '0, "R1 buses zero", int'(addr_o | data_o), 0);
    chk(!busy && !done_o && !berr_o, "R1 flags low", int'({busy, done_o, berr_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bus_vec() == IDLE_V && !busy, "R1 idle after reset", bus_vec(), IDLE_V);

    for (int k = 0; k < 6; k++)
      run_vec(VEC[k][63:48], VEC[k][47:32], int'(VEC[k][31:24]), int'(VEC[k][23:16]),
              int'(VEC[k][15:8]), int'(VEC[k][7:0]), 1'b0);

    // R9 start during strobe phase is ignored
    run_vec(16'h5555, 16'h3C3C, 4, 2, 20, 0, 1'b1);
    begin
      bit quiet = 1;
      for (int i = 0; i < 10; i++) begin
        if (busy || addr_oe) quiet = 0;
        @(negedge clk);
      end
      chk(quiet, "R9 no second transfer", int'(quiet), 1);
    end
    chk(bus_vec() == IDLE_V && addr_o == '0, "R1 idle levels after traffic", bus_vec(), IDLE_V);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule